// File: doc/BRIEF.md
# Chunked I2C Master Transfer Sequencer

This block takes one I2C message at a time and drives a byte-level bus engine with commands that each move at most four bytes. A message longer than four bytes becomes a run of commands. Every command except the last asks the engine to keep the bus held, so no STOP is sent between commands. When the message is not the final one of a combined transfer, its last command asks for a repeated START instead of a STOP.

For a write, the bytes of a command are copied from an upstream byte source into the engine's data buffer before the command is issued. For a read, the bytes are moved from the engine's buffer to a downstream sink only after the engine reports that the command completed in full. The block also forms the target address bytes for 7-bit and 10-bit addressing and rejects bad requests without touching the bus. It watches the engine's pending flag with a timeout. It turns short counts, engine errors and timeouts into an error result, and sends a halt command when the bus would otherwise be left held. A small helper derives the engine clock divider from the reference clock frequency in MHz.

Top module: `i2c_chunk_seq`

## Requirements
- R1: A message of L bytes produces ceil(L/4) commands. Each command's field cmd_word[1:0] holds the byte count of that command minus one, and that count is min(4, bytes still to send).
- R2: cmd_word[2] (hold bus, no STOP) is 1 on every command of a message except its last command, where it is 0.
- R3: cmd_word[3] (repeated START) is 1 only on the last command of a message started with msg_last=0, and 0 on all other commands. cmd_word[4] equals the latched msg_read.
- R4: For a write, exactly the bytes of a command are pushed into the engine buffer (buf_wr) in source order, before that command's cmd_valid, and no byte is pushed while eng_pending is high.
- R5: For a read, the bytes of a command go to the sink (snk_valid) only after the engine has cleared eng_pending with eng_xcnt equal to the requested count and eng_err low. Nothing is unloaded for a failed command.
- R6: For a 7-bit address, tgt_lo = addr<<1 (bits 7:0) and tgt_hi = 0. For a 10-bit address, tgt_lo = addr[7:0] and tgt_hi = 0xF0 | ((addr>>7) & 0x06).
- R7: A 7-bit address above 0x7F, a 10-bit address above 0x3FF, or a zero length ends the message with done and err set and no command issued.
- R8: If eng_xcnt differs from the requested count, err is set and the message ends. halt_cmd pulses once first unless the command was the last one of a final message (msg_last=1).
- R9: If eng_pending is still high in the TMO_CYCLES-th cycle of waiting, halt_cmd pulses and err is set. If pending clears in that very cycle, completion wins and no timeout occurs.
- R10: clk_div = (m + 9)/10 - 1, where m is ref_mhz clamped to the range 20..150.
- R11: done pulses for exactly one cycle per accepted start. At that cycle xfer_bytes equals the bytes of all fully completed commands, and err is 0 on success.
- R12: If eng_err is high when pending clears, err is set, the message ends without halt_cmd, and no further command is issued.
- R13: After reset, done, cmd_valid, halt_cmd, buf_wr, buf_rd and snk_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_mhz | input | 8 | Reference clock frequency in MHz |
| clk_div | output | 4 | Derived engine clock divider |
| start | input | 1 | Start a message (accepted when idle) |
| msg_len | input | LEN_W | Message length in bytes |
| msg_read | input | 1 | 1 = read, 0 = write |
| msg_last | input | 1 | 1 = final message of the transfer |
| tgt_addr | input | 11 | Target address |
| tgt_ten | input | 1 | 1 = 10-bit addressing |
| tgt_lo | output | 8 | Low address byte for the engine |
| tgt_hi | output | 8 | High address byte for the engine (10-bit only) |
| src_rd | output | 1 | Pop one byte from the write source |
| src_data | input | 8 | Current write source byte |
| buf_wr | output | 1 | Push one byte into the engine buffer |
| buf_wdata | output | 8 | Byte pushed into the engine buffer |
| buf_rd | output | 1 | Pop one byte from the engine buffer |
| buf_rdata | input | 8 | Current engine buffer byte |
| snk_valid | output | 1 | Read byte delivered to the sink |
| snk_data | output | 8 | Read byte |
| cmd_valid | output | 1 | Command strobe to the engine |
| cmd_word | output | 5 | {read, repeated START, hold, count-1[1:0]} |
| halt_cmd | output | 1 | Abort strobe to the engine |
| eng_pending | input | 1 | Engine busy with a command |
| eng_xcnt | input | 3 | Bytes the engine completed |
| eng_err | input | 1 | Engine reported a bus error |
| done | output | 1 | One-cycle end-of-message pulse |
| err | output | 1 | Message failed (valid with done) |
| xfer_bytes | output | LEN_W | Bytes completed in the message |

## Verification
Completion and timeout can fall in the same waiting cycle. The bench gives its engine model a latency of exactly TMO_CYCLES-1 so that pending clears in the cycle where the timeout limit is reached, and expects a clean completion with no halt. One cycle more of latency must give a halt and an error. A short count can also fall on a command that is both last and part of a final message. That case is judged against one that is last but non-final, where only the second may raise halt_cmd.

// File: rtl/i2c_chunk_seq_pkg.sv
package i2c_chunk_seq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_LOAD,
        SQ_ISSUE,
        SQ_WAIT,
        SQ_UNLOAD,
        SQ_HALT,
        SQ_FIN
    } sq_state_e;

    // bit 4 read, bit 3 repeated start, bit 2 hold bus, bits 1:0 count-1
    typedef struct packed {
        logic       rd;
        logic       rstart;
        logic       hold;
        logic [1:0] cnt_m1;
    } sq_cmd_t;

endpackage

// File: rtl/i2c_clkdiv_calc.sv
module i2c_clkdiv_calc #(
    parameter int MHZ_MIN = 20,
    parameter int MHZ_MAX = 150
) (
    input  logic [7:0] ref_mhz,
    output logic [3:0] div
);
    localparam logic [7:0] LO = 8'(MHZ_MIN);
    localparam logic [7:0] HI = 8'(MHZ_MAX);
    localparam logic [3:0] DIV_LO = 4'((MHZ_MIN + 9) / 10 - 1);
    localparam logic [3:0] DIV_HI = 4'((MHZ_MAX + 9) / 10 - 1);

    logic [7:0] mhz_c;
    logic [8:0] sum;
    logic [8:0] quo;

    always_comb begin
        if (ref_mhz < LO)      mhz_c = LO;
        else if (ref_mhz > HI) mhz_c = HI;
        else                   mhz_c = ref_mhz;
        sum = {1'b0, mhz_c} + 9'd9;
        quo = sum / 9'd10;
        div = 4'(quo - 9'd1);
    end

    // R10 divider stays inside the clamped range
    always_comb begin
        if (!$isunknown(ref_mhz)) begin
            a_r10_div_range: assert (div >= DIV_LO && div <= DIV_HI);
        end
    end
endmodule

// File: rtl/i2c_addr_form.sv
module i2c_addr_form #(
    parameter int ADDR_W = 11
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              ten,
    output logic [7:0]        lo,
    output logic [7:0]        hi,
    output logic              bad
);
    always_comb begin
        if (ten) begin
            lo  = addr[7:0];
            hi  = {4'hF, 1'b0, addr[9:8], 1'b0};
            bad = |addr[ADDR_W-1:10];
        end else begin
            lo  = {addr[6:0], 1'b0};
            hi  = 8'h00;
            bad = |addr[ADDR_W-1:7];
        end
    end
endmodule

// File: rtl/i2c_chunk_plan.sv
module i2c_chunk_plan #(
    parameter int LEN_W     = 8,
    parameter int CHUNK_MAX = 4,
    localparam int SZ_W     = $clog2(CHUNK_MAX + 1)
) (
    input  logic [LEN_W-1:0] rem,
    output logic [SZ_W-1:0]  size,
    output logic             last
);
    localparam logic [LEN_W-1:0] CMAX = LEN_W'(CHUNK_MAX);

    always_comb begin
        last = (rem <= CMAX);
        size = last ? SZ_W'(rem) : SZ_W'(CHUNK_MAX);
    end
endmodule

// File: rtl/i2c_chunk_seq.sv
module i2c_chunk_seq
    import i2c_chunk_seq_pkg::*;
#(
    parameter int LEN_W      = 8,
    parameter int TMO_CYCLES = 1024,
    parameter int ADDR_W     = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        ref_mhz,
    output logic [3:0]        clk_div,
    input  logic              start,
    input  logic [LEN_W-1:0]  msg_len,
    input  logic              msg_read,
    input  logic              msg_last,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic              tgt_ten,
    output logic [7:0]        tgt_lo,
    output logic [7:0]        tgt_hi,
    output logic              src_rd,
    input  logic [7:0]        src_data,
    output logic              buf_wr,
    output logic [7:0]        buf_wdata,
    output logic              buf_rd,
    input  logic [7:0]        buf_rdata,
    output logic              snk_valid,
    output logic [7:0]        snk_data,
    output logic              cmd_valid,
    output logic [4:0]        cmd_word,
    output logic              halt_cmd,
    input  logic              eng_pending,
    input  logic [2:0]        eng_xcnt,
    input  logic              eng_err,
    output logic              done,
    output logic              err,
    output logic [LEN_W-1:0]  xfer_bytes
);
    localparam int CHUNK_MAX = 4;
    localparam int SZ_W      = $clog2(CHUNK_MAX + 1);
    localparam int TMO_W     = $clog2(TMO_CYCLES + 1);
    localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TMO_CYCLES - 1);

    typedef struct packed {
        sq_state_e        st;
        logic [LEN_W-1:0] rem;
        logic [LEN_W-1:0] moved;
        logic [SZ_W-1:0]  idx;
        logic             rd;
        logic             fin;
        logic             err;
        logic [TMO_W-1:0] tmo;
        logic [7:0]       lo;
        logic [7:0]       hi;
    } sq_regs_t;

    sq_regs_t r_q, r_d;

    logic [SZ_W-1:0] size;
    logic            is_last;
    logic [7:0]      a_lo, a_hi;
    logic            a_bad;
    sq_cmd_t         cmd_c;

    i2c_clkdiv_calc u_div (
        .ref_mhz (ref_mhz),
        .div     (clk_div)
    );

    i2c_addr_form #(.ADDR_W(ADDR_W)) u_addr (
        .addr (tgt_addr),
        .ten  (tgt_ten),
        .lo   (a_lo),
        .hi   (a_hi),
        .bad  (a_bad)
    );

    i2c_chunk_plan #(.LEN_W(LEN_W), .CHUNK_MAX(CHUNK_MAX)) u_plan (
        .rem  (r_q.rem),
        .size (size),
        .last (is_last)
    );

    always_comb begin
        r_d       = r_q;
        src_rd    = 1'b0;
        buf_wr    = 1'b0;
        buf_rd    = 1'b0;
        snk_valid = 1'b0;
        cmd_valid = 1'b0;
        halt_cmd  = 1'b0;
        done      = 1'b0;

        cmd_c.rd     = r_q.rd;
        cmd_c.rstart = is_last && !r_q.fin;
        cmd_c.hold   = !is_last;
        cmd_c.cnt_m1 = 2'(size - SZ_W'(1));

        unique case (r_q.st)
            SQ_IDLE: begin
                if (start) begin
                    r_d.rd    = msg_read;
                    r_d.fin   = msg_last;
                    r_d.rem   = msg_len;
                    r_d.moved = '0;
                    r_d.idx   = '0;
                    r_d.lo    = a_lo;
                    r_d.hi    = a_hi;
                    if (a_bad || msg_len == '0) begin
                        r_d.err = 1'b1;
                        r_d.st  = SQ_FIN;
                    end else begin
                        r_d.err = 1'b0;
                        r_d.st  = msg_read ? SQ_ISSUE : SQ_LOAD;
                    end
                end
            end
            SQ_LOAD: begin
                src_rd = 1'b1;
                buf_wr = 1'b1;
                if (r_q.idx == size - SZ_W'(1)) begin
                    r_d.idx = '0;
                    r_d.st  = SQ_ISSUE;
                end else begin
                    r_d.idx = r_q.idx + SZ_W'(1);
                end
            end
            SQ_ISSUE: begin
                cmd_valid = 1'b1;
                r_d.tmo   = '0;
                r_d.st    = SQ_WAIT;
            end
            SQ_WAIT: begin
                if (!eng_pending) begin
                    if (eng_err) begin
                        r_d.err = 1'b1;
                        r_d.st  = SQ_FIN;
                    end else if (eng_xcnt != 3'(size)) begin
                        r_d.err = 1'b1;
                        r_d.st  = (is_last && r_q.fin) ? SQ_FIN : SQ_HALT;
                    end else begin
                        r_d.moved = r_q.moved + LEN_W'(size);
                        if (r_q.rd) begin
                            r_d.idx = '0;
                            r_d.st  = SQ_UNLOAD;
                        end else begin
                            r_d.rem = r_q.rem - LEN_W'(size);
                            r_d.st  = is_last ? SQ_FIN : SQ_LOAD;
                        end
                    end
                end else if (r_q.tmo == TMO_LAST) begin
                    r_d.err = 1'b1;
                    r_d.st  = SQ_HALT;
                end else begin
                    r_d.tmo = r_q.tmo + TMO_W'(1);
                end
            end
            SQ_UNLOAD: begin
                buf_rd    = 1'b1;
                snk_valid = 1'b1;
                if (r_q.idx == size - SZ_W'(1)) begin
                    r_d.idx = '0;
                    r_d.rem = r_q.rem - LEN_W'(size);
                    r_d.st  = is_last ? SQ_FIN : SQ_ISSUE;
                end else begin
                    r_d.idx = r_q.idx + SZ_W'(1);
                end
            end
            SQ_HALT: begin
                halt_cmd = 1'b1;
                r_d.st   = SQ_FIN;
            end
            SQ_FIN: begin
                done   = 1'b1;
                r_d.st = SQ_IDLE;
            end
            default: r_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: SQ_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign buf_wdata  = src_data;
    assign snk_data   = buf_rdata;
    assign cmd_word   = cmd_c;
    assign err        = r_q.err;
    assign xfer_bytes = r_q.moved;
    assign tgt_lo     = r_q.lo;
    assign tgt_hi     = r_q.hi;

    // R11 done is a single-cycle pulse
    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8 a halt is always followed by an erroneous end
    a_r8_halt_then_fail: assert property (@(posedge clk) disable iff (!rst_n)
        halt_cmd |=> (done && err));

    // R4 no buffer load while the engine is busy
    a_r4_load_engine_idle: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr |-> !eng_pending);

    // R5 unloading starts only after a clean completion
    a_r5_unload_after_ok: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(snk_valid) |-> $past(!eng_pending && !eng_err));

    // R9 wait counter never passes its limit
    a_r9_tmo_bound: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.tmo <= TMO_LAST);

    // R1 no command once nothing remains
    a_r1_cmd_has_bytes: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (r_q.rem != '0));

    // R12 engine error ends the message with no halt
    a_r12_err_no_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == SQ_WAIT && !eng_pending && eng_err) |=> (done && !halt_cmd));
endmodule

// File: tb/tb_i2c_chunk_seq.sv
`timescale 1ns/1ps
module tb_i2c_chunk_seq;
    localparam int LEN_W = 8;
    localparam int TMO   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] ref_mhz = 8'd50;
    logic [3:0] clk_div;
    logic start = 1'b0;
    logic [LEN_W-1:0] msg_len = '0;
    logic msg_read = 1'b0, msg_last = 1'b0;
    logic [10:0] tgt_addr = '0;
    logic tgt_ten = 1'b0;
    logic [7:0] tgt_lo, tgt_hi;
    logic src_rd, buf_wr, buf_rd, snk_valid, cmd_valid, halt_cmd, done, err;
    logic [7:0] src_data, buf_wdata, buf_rdata, snk_data;
    logic [4:0] cmd_word;
    logic eng_pending = 1'b0;
    logic [2:0] eng_xcnt = '0;
    logic eng_err = 1'b0;
    logic [LEN_W-1:0] xfer_bytes;

    int errs = 0, checks = 0;

    always #5 clk = ~clk;

    i2c_chunk_seq #(.LEN_W(LEN_W), .TMO_CYCLES(TMO)) dut (
        .clk(clk), .rst_n(rst_n), .ref_mhz(ref_mhz), .clk_div(clk_div),
        .start(start), .msg_len(msg_len), .msg_read(msg_read), .msg_last(msg_last),
        .tgt_addr(tgt_addr), .tgt_ten(tgt_ten), .tgt_lo(tgt_lo), .tgt_hi(tgt_hi),
        .src_rd(src_rd), .src_data(src_data), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
        .buf_rd(buf_rd), .buf_rdata(buf_rdata), .snk_valid(snk_valid), .snk_data(snk_data),
        .cmd_valid(cmd_valid), .cmd_word(cmd_word), .halt_cmd(halt_cmd),
        .eng_pending(eng_pending), .eng_xcnt(eng_xcnt), .eng_err(eng_err),
        .done(done), .err(err), .xfer_bytes(xfer_bytes)
    );

    // behavioural environment: byte source, engine buffer, engine
    logic [7:0] src_q[$];
    logic [7:0] rdd_q[$];
    logic [7:0] got_w[$];
    logic [7:0] got_r[$];
    logic [4:0] exp_cmd[$];
    int exp_ld[$];
    int short_at = -1, err_at = -1, lat = 2, cmd_no = 0, halts = 0, left = 0;

    always @* src_data  = (src_q.size() > 0) ? src_q[0] : 8'h00;
    always @* buf_rdata = (rdd_q.size() > 0) ? rdd_q[0] : 8'h00;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    always @(posedge clk) begin
        if (src_rd && src_q.size() > 0) void'(src_q.pop_front());
        if (buf_wr) got_w.push_back(buf_wdata);
        if (buf_rd && rdd_q.size() > 0) void'(rdd_q.pop_front());
        if (snk_valid) got_r.push_back(snk_data);
        if (cmd_valid) begin
            eng_pending <= 1'b1;
            left        <= lat;
            eng_xcnt    <= (cmd_no == short_at) ? 3'(cmd_word[1:0]) : 3'(cmd_word[1:0] + 2'd0) + 3'd1;
            eng_err     <= (cmd_no == err_at);
            cmd_no      <= cmd_no + 1;
        end else if (halt_cmd) begin
            eng_pending <= 1'b0;
        end else if (eng_pending) begin
            if (left <= 1) eng_pending <= 1'b0;
            else left <= left - 1;
        end
    end

    // per-cycle comparison against the reference command stream
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_valid) begin
                if (exp_cmd.size() == 0) begin
                    chk(0, "R7,R12 unexpected command", cmd_word, 0);
                end else begin
                    chk(cmd_word == exp_cmd[0], "R1,R2,R3 command word", cmd_word, exp_cmd[0]);
                    chk(got_w.size() == exp_ld[0], "R4 bytes loaded before command", got_w.size(), exp_ld[0]);
                    void'(exp_cmd.pop_front());
                    void'(exp_ld.pop_front());
                end
            end
            if (snk_valid) chk(!eng_pending, "R5 unload while pending", eng_pending, 0);
            if (halt_cmd) halts++;
        end
    end

    task automatic run_msg(input int len, input bit rd, input int adr, input bit ten,
                           input bit fin, input int sh, input int ee, input int lt);
        int rem = len, c = 0, moved = 0, loaded = 0, rdok = 0, wd = 0;
        bit xerr = 0, xhalt = 0, bad;
        int xlo, xhi;
        bad = ten ? (adr > 'h3FF) : (adr > 'h7F);
        short_at = sh; err_at = ee; lat = lt; cmd_no = 0; halts = 0;
        got_w.delete(); got_r.delete(); src_q.delete(); rdd_q.delete();
        exp_cmd.delete(); exp_ld.delete();
        for (int i = 0; i < len; i++) begin
            src_q.push_back(8'((i * 7 + len) & 'hFF));
            rdd_q.push_back(8'((i * 13 + 5) & 'hFF));
        end
        if (bad || len == 0) begin
            xerr = 1;
        end else begin
            while (rem > 0) begin
                int sz = (rem > 4) ? 4 : rem;
                bit lst = (rem <= 4);
                if (!rd) loaded += sz;
                exp_cmd.push_back({rd, lst && !fin, !lst, 2'(sz - 1)});
                exp_ld.push_back(loaded);
                if (c == ee) begin xerr = 1; break; end
                if (lt >= TMO) begin xerr = 1; xhalt = 1; break; end
                if (c == sh) begin xerr = 1; xhalt = !(lst && fin); break; end
                moved += sz;
                if (rd) rdok += sz;
                rem -= sz;
                c++;
            end
        end
        xlo = ten ? (adr & 'hFF) : ((adr << 1) & 'hFF);
        xhi = ten ? ('hF0 | ((adr >> 7) & 6)) : 0;
        @(negedge clk);
        msg_len = LEN_W'(len); msg_read = rd; msg_last = fin;
        tgt_addr = 11'(adr); tgt_ten = ten; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && wd < 5000) begin
            @(negedge clk);
            wd++;
        end
        chk(done == 1'b1, "R11 done reached", done, 1);
        chk(err == xerr, "R7,R8,R9,R12 error flag", err, xerr);
        chk(int'(xfer_bytes) == moved, "R11 bytes transferred", xfer_bytes, moved);
        chk(halts == int'(xhalt), "R8,R9 halt count", halts, xhalt);
        chk(exp_cmd.size() == 0, "R1 missing commands", exp_cmd.size(), 0);
        chk(got_w.size() == loaded, "R4 bytes written", got_w.size(), loaded);
        for (int i = 0; i < got_w.size() && i < loaded; i++)
            chk(got_w[i] == 8'((i * 7 + len) & 'hFF), "R4 write order", got_w[i], (i * 7 + len) & 'hFF);
        chk(got_r.size() == rdok, "R5 bytes read", got_r.size(), rdok);
        for (int i = 0; i < got_r.size() && i < rdok; i++)
            chk(got_r[i] == 8'((i * 13 + 5) & 'hFF), "R5 read order", got_r[i], (i * 13 + 5) & 'hFF);
        if (!bad) begin
            chk(int'(tgt_lo) == xlo, "R6 low address byte", tgt_lo, xlo);
            chk(int'(tgt_hi) == xhi, "R6 high address byte", tgt_hi, xhi);
        end
        @(negedge clk);
        chk(done == 1'b0, "R11 done single pulse", done, 0);
        wd = 0;
        while (eng_pending && wd < 100) begin @(negedge clk); wd++; end
        repeat (2) @(negedge clk);
    endtask

    task automatic div_chk(input int mhz);
        int m, e;
        m = (mhz < 20) ? 20 : (mhz > 150) ? 150 : mhz;
        e = (m + 9) / 10 - 1;
        ref_mhz = 8'(mhz);
        #1;
        chk(int'(clk_div) == e, "R10 clock divider", clk_div, e);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk({done, cmd_valid, halt_cmd, buf_wr, buf_rd, snk_valid} == 6'b0,
            "R13 reset outputs", {done, cmd_valid, halt_cmd, buf_wr, buf_rd, snk_valid}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_msg(1,   0, 'h50,  0, 1, -1, -1, 2);          // R1 single byte write
        run_msg(4,   0, 'h7F,  0, 1, -1, -1, 3);          // R2 exact chunk
        run_msg(5,   0, 'h21,  0, 0, -1, -1, 1);          // R3 combined, rstart on last
        run_msg(9,   1, 'h3C,  0, 1, -1, -1, 2);          // R5 read 4,4,1
        run_msg(3,   1, 'h2A5, 1, 0, -1, -1, 2);          // R6 10-bit address
        run_msg(2,   0, 'h3FF, 1, 1, -1, -1, 1);          // R6 top 10-bit address
        run_msg(8,   0, 'h11,  0, 1, 0, -1, 2);           // R8 short on chained chunk
        run_msg(6,   1, 'h12,  0, 1, 1, -1, 2);           // R8 short on last of final
        run_msg(3,   0, 'h13,  0, 0, 0, -1, 2);           // R8 short on last of non-final
        run_msg(8,   1, 'h14,  0, 1, -1, 1, 2);           // R12 engine error
        run_msg(6,   0, 'h15,  0, 1, -1, -1, TMO - 1);    // R9 completion in limit cycle
        run_msg(6,   0, 'h16,  0, 1, -1, -1, TMO);        // R9 timeout
        run_msg(0,   0, 'h17,  0, 1, -1, -1, 2);          // R7 zero length
        run_msg(2,   0, 'h80,  0, 1, -1, -1, 2);          // R7 bad 7-bit
        run_msg(2,   1, 'h400, 1, 1, -1, -1, 2);          // R7 bad 10-bit
        run_msg(255, 1, 'h55,  0, 0, -1, -1, 1);          // R1 longest message

        div_chk(0);   div_chk(19);  div_chk(20);  div_chk(21);
        div_chk(50);  div_chk(150); div_chk(151); div_chk(255);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        errs++;
        $display("FAIL R11 watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule